// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel in waveform generation mode. One up-counter, stepped by a selectable clock-enable tick, returns to zero after it reaches a shared period value. Two pulse outputs, A and B, are derived from that counter. Each output has its own duty compare value and its own three action fields. One field acts on a duty match, one on a period match and one on a software trigger. Each action can leave the output alone, set it, clear it or toggle it.

Software programs the channel through a simple write port. The port loads a mode word (tick source and the six action fields), the two duty compares, the period and a command word. The command word can start the clock, stop it or issue a software trigger. A trigger restarts the count from zero and forces each output to its programmed trigger level. The usual setup for a normal-polarity output is: set on the period match, clear on the duty match, set on the trigger. For inverted polarity, these are swapped. When a duty value must be constant (zero, or equal to the period), the compare actions are left at none and the trigger level is held.

Top module: `wave_timer_chan`

## Requirements
- R1: While running, the counter advances by one on each selected tick. A tick that finds the count equal to the period loads zero instead.
- R2: Mode bits [2:0] choose the tick. A value below NUM_PRESC picks `presc_tick_i[value]`. Any larger value picks `slow_tick_i`. The counter ignores every tick that is not selected.
- R3: A duty match is a selected tick while the count equals that output's compare value. It applies the duty action field: bits [5:4] of the mode word for A, bits [13:12] for B. Action codes are 00 none, 01 set, 10 clear, 11 toggle.
- R4: A period match (tick with count equal to period) applies each output's period action field: mode bits [7:6] for A, [15:14] for B.
- R5: Writing a command with bit 2 set zeroes the count on that same edge. On that edge it also applies each output's trigger action field: mode bits [9:8] for A, [17:16] for B.
- R6: On a cycle with no trigger and no match, or whose matching fields are none, both outputs keep their level. Counting still goes on.
- R7: A command with disable (bit 1) and trigger (bit 2) together forces the trigger levels, zeroes the count and leaves the counter stopped.
- R8: Command bit 0 starts the clock and bit 1 stops it; stop wins if both are set. The write edge still uses the previous run state. While stopped, count and outputs hold.
- R9: Priority per output: trigger action, then period action, then duty action.
- R10: The toggle code inverts an output on each event that selects it.
- R11: After reset the count is zero, both outputs are low and the counter is stopped.
- R12: Write addresses: 0 mode, 1 compare A, 2 compare B, 3 period, 4 command. A written value is in effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_tick_i | input | NUM_PRESC | Prescaled clock-enable ticks |
| slow_tick_i | input | 1 | Slow clock-enable tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| wave_a_o | output | 1 | Output A |
| wave_b_o | output | 1 | Output B |
| count_o | output | CNT_W | Current counter value |

## Verification
The hardest cases are collisions at one edge: a software trigger on the cycle where the count sits on the period, and a duty compare equal to the period, so both matches fire together. The bench reaches the first by counting ticks from a known trigger and issuing the next trigger exactly as the count reaches the period. It reaches the second by programming opposing duty and period actions with equal values. A sweep over every duty below small periods, with both polarities at once, covers the ordinary waveform shapes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    // Field order gives duty at the low bits, trigger at the high bits.
    typedef struct packed {
        act_e trg;
        act_e per;
        act_e duty;
    } out_act_t;

    localparam int ADDR_MODE = 0;
    localparam int ADDR_CMPA = 1;
    localparam int ADDR_CMPB = 2;
    localparam int ADDR_PER  = 3;
    localparam int ADDR_CMD  = 4;

    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_DIS_BIT = 1;
    localparam int CMD_TRG_BIT = 2;

    localparam int ACT_A_LSB = 4;
    localparam int ACT_B_LSB = 12;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/wtc_tick_sel.sv
module wtc_tick_sel #(
    parameter int NUM_PRESC = 4,
    parameter int SEL_W     = 3
) (
    input  logic [NUM_PRESC-1:0] presc_i,
    input  logic                 slow_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 tick_o
);

    always_comb begin
        tick_o = slow_i;
        for (int i = 0; i < NUM_PRESC; i++) begin
            if (sel_i == SEL_W'(i)) tick_o = presc_i[i];
        end
    end

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             step_o,
    output logic             per_hit_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d   = state_q;
        step_o    = state_q.run && tick_i;
        per_hit_o = step_o && (state_q.cnt == period_i);
        if (stop_i)       state_d.run = 1'b0;
        else if (start_i) state_d.run = 1'b1;
        if (trig_i)         state_d.cnt = '0;
        else if (per_hit_o) state_d.cnt = '0;
        else if (step_o)    state_d.cnt = state_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_o = state_q.cnt;

    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (count_o == '0)); // R5

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.run && !trig_i) |=> $stable(count_o)); // R8

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && tick_i && !trig_i && count_o != period_i)
        |=> (count_o == $past(count_o) + CNT_W'(1))); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && tick_i && !trig_i && count_o == period_i)
        |=> (count_o == '0)); // R1

endmodule

// File: rtl/wtc_action.sv
module wtc_action
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             step_i,
    input  logic             per_hit_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  out_act_t         act_i,
    output logic             wave_o
);

    logic wave_d, wave_q;
    logic duty_hit;

    always_comb begin
        duty_hit = step_i && (count_i == cmp_i);
        wave_d   = wave_q;
        if (trig_i)         wave_d = apply_act(act_i.trg, wave_q);
        else if (per_hit_i) wave_d = apply_act(act_i.per, wave_q);
        else if (duty_hit)  wave_d = apply_act(act_i.duty, wave_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave_o = wave_q;

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !per_hit_i && !(step_i && count_i == cmp_i))
        |=> $stable(wave_o)); // R6

    AST_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && act_i.trg == ACT_SET) |=> wave_o); // R5

    AST_TRIG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && act_i.trg == ACT_CLR) |=> !wave_o); // R9

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_PRESC = 4,
    parameter int SEL_W     = 3,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PRESC-1:0] presc_tick_i,
    input  logic                 slow_tick_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic                 wave_a_o,
    output logic                 wave_b_o,
    output logic [CNT_W-1:0]     count_o
);

    localparam int ACT_W  = $bits(out_act_t);
    localparam int N_OUTS = 2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        out_act_t         act_a;
        out_act_t         act_b;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [CNT_W-1:0] per;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cmd_wr, cmd_en, cmd_dis, cmd_trg;
    logic tick, step, per_hit;
    logic unused_wdata;

    assign unused_wdata = ^wr_data_i;

    always_comb begin
        cfg_d   = cfg_q;
        cmd_wr  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMD));
        cmd_en  = cmd_wr && wr_data_i[CMD_EN_BIT];
        cmd_dis = cmd_wr && wr_data_i[CMD_DIS_BIT];
        cmd_trg = cmd_wr && wr_data_i[CMD_TRG_BIT];
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_W'(ADDR_MODE): begin
                    cfg_d.sel   = wr_data_i[SEL_W-1:0];
                    cfg_d.act_a = out_act_t'(wr_data_i[ACT_A_LSB +: ACT_W]);
                    cfg_d.act_b = out_act_t'(wr_data_i[ACT_B_LSB +: ACT_W]);
                end
                ADDR_W'(ADDR_CMPA): cfg_d.cmp_a = wr_data_i[CNT_W-1:0];
                ADDR_W'(ADDR_CMPB): cfg_d.cmp_b = wr_data_i[CNT_W-1:0];
                ADDR_W'(ADDR_PER):  cfg_d.per   = wr_data_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    wtc_tick_sel #(.NUM_PRESC(NUM_PRESC), .SEL_W(SEL_W)) u_tick (
        .presc_i (presc_tick_i),
        .slow_i  (slow_tick_i),
        .sel_i   (cfg_q.sel),
        .tick_o  (tick)
    );

    wtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (cmd_en),
        .stop_i    (cmd_dis),
        .trig_i    (cmd_trg),
        .period_i  (cfg_q.per),
        .count_o   (count_o),
        .step_o    (step),
        .per_hit_o (per_hit)
    );

    logic [CNT_W-1:0] cmp_arr  [N_OUTS];
    out_act_t         act_arr  [N_OUTS];
    logic             wave_arr [N_OUTS];

    assign cmp_arr[0] = cfg_q.cmp_a;
    assign cmp_arr[1] = cfg_q.cmp_b;
    assign act_arr[0] = cfg_q.act_a;
    assign act_arr[1] = cfg_q.act_b;

    for (genvar g = 0; g < N_OUTS; g++) begin : g_out
        wtc_action #(.CNT_W(CNT_W)) u_act (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_i    (cmd_trg),
            .step_i    (step),
            .per_hit_i (per_hit),
            .count_i   (count_o),
            .cmp_i     (cmp_arr[g]),
            .act_i     (act_arr[g]),
            .wave_o    (wave_arr[g])
        );
    end

    assign wave_a_o = wave_arr[0];
    assign wave_b_o = wave_arr[1];

    AST_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(ADDR_PER))
        |=> (cfg_q.per == $past(wr_data_i[CNT_W-1:0]))); // R12

endmodule

// File: tb/tb_wave_timer_chan.sv
module tb_wave_timer_chan;

    localparam int CNT_W = 16;
    localparam int NP    = 4;
    localparam int NONE = 0, SET = 1, CLR = 2, TGL = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     presc = '1;
    logic              slow = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              wave_a, wave_b;
    logic [CNT_W-1:0]  count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wave_timer_chan dut (
        .clk(clk), .rst_n(rst_n), .presc_tick_i(presc), .slow_tick_i(slow),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .wave_a_o(wave_a), .wave_b_o(wave_b), .count_o(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int mk_mode(int sel, int da, int pa, int ta, int db, int pb, int tb);
        return sel | (da << 4) | (pa << 6) | (ta << 8) | (db << 12) | (pb << 14) | (tb << 16);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int held_c, held_a, ticks;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 count", int'(count), 0);
        chk("R11 wave_a", int'(wave_a), 0);
        chk("R11 wave_b", int'(wave_b), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 stopped after reset", int'(count), 0);

        // Sweep: A normal polarity, B inverted (R1 R3 R4 R5 R12)
        wr(0, mk_mode(0, CLR, SET, SET, SET, CLR, CLR));
        for (int p = 1; p <= 6; p++) begin
            for (int d = 0; d < p; d++) begin
                int db;
                db = p - 1 - d;
                wr(1, d); wr(2, db); wr(3, p);
                wr(4, 5);
                for (int k = 0; k < 2 * (p + 1); k++) begin
                    int c;
                    c = k % (p + 1);
                    chk("R1 count", int'(count), c);
                    chk("R3 R4 R5 wave_a", int'(wave_a), (c <= d) ? 1 : 0);
                    chk("R3 R4 R5 wave_b", int'(wave_b), (c <= db) ? 0 : 1);
                    @(negedge clk);
                end
            end
        end

        // R2 prescaled selection
        presc = 4'b1011;
        wr(3, 200);
        wr(0, mk_mode(2, NONE, NONE, NONE, NONE, NONE, NONE));
        wr(4, 5);
        ticks = 0;
        for (int i = 0; i < 30; i++) begin
            presc = (i % 3 == 0) ? 4'b1111 : 4'b1011;
            if (i % 3 == 0) ticks++;
            @(negedge clk);
        end
        presc = 4'b1011;
        chk("R2 prescaled tick count", int'(count), ticks);
        // R2 slow selection
        wr(0, mk_mode(4, NONE, NONE, NONE, NONE, NONE, NONE));
        wr(4, 5);
        presc = 4'b1111;
        for (int i = 0; i < 20; i++) begin
            slow = (i % 5 == 0);
            @(negedge clk);
        end
        slow = 1'b0;
        chk("R2 slow tick count", int'(count), 4);

        // R6 no compare actions: trigger level held
        wr(0, mk_mode(0, NONE, NONE, SET, NONE, NONE, CLR));
        wr(1, 2); wr(2, 4); wr(3, 4);
        wr(4, 5);
        for (int k = 0; k < 12; k++) begin
            chk("R6 wave_a held", int'(wave_a), 1);
            chk("R6 wave_b held", int'(wave_b), 0);
            @(negedge clk);
        end
        chk("R6 counting continues", int'(count), 12 % 5);

        // R7 disable with trigger
        wr(0, mk_mode(0, CLR, SET, CLR, NONE, NONE, SET));
        wr(1, 2); wr(3, 5);
        wr(4, 5);
        repeat (3) @(negedge clk);
        wr(4, 6);
        for (int k = 0; k < 8; k++) begin
            chk("R7 count zero and stopped", int'(count), 0);
            chk("R7 wave_a forced", int'(wave_a), 0);
            chk("R7 wave_b forced", int'(wave_b), 1);
            @(negedge clk);
        end

        // R8 disable holds, enable resumes
        wr(0, mk_mode(0, CLR, SET, SET, NONE, NONE, NONE));
        wr(4, 5);
        repeat (4) @(negedge clk);
        wr(4, 2);
        held_c = int'(count);
        held_a = int'(wave_a);
        chk("R8 last step on disable edge", held_c, 5);
        chk("R8 wave_a low", held_a, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R8 count held", int'(count), held_c);
            chk("R8 wave_a held", int'(wave_a), held_a);
        end
        wr(4, 1);
        chk("R8 no step on enable edge", int'(count), 5);
        @(negedge clk);
        chk("R8 resumed wrap", int'(count), 0);
        chk("R8 resumed period set", int'(wave_a), 1);

        // R9 period action beats duty action
        wr(0, mk_mode(0, CLR, SET, CLR, NONE, NONE, NONE));
        wr(1, 3); wr(3, 3);
        wr(4, 5);
        for (int k = 0; k < 12; k++) begin
            chk("R9 period over duty", int'(wave_a), (k >= 4) ? 1 : 0);
            @(negedge clk);
        end

        // R9 trigger beats period action
        wr(1, 1);
        wr(4, 5);
        repeat (3) @(negedge clk);
        chk("R9 count at period", int'(count), 3);
        wr(4, 5);
        chk("R9 trigger restarts", int'(count), 0);
        chk("R9 trigger over period", int'(wave_a), 0);

        // R10 toggle on period
        wr(0, mk_mode(0, NONE, TGL, CLR, NONE, NONE, NONE));
        wr(3, 2);
        wr(4, 5);
        for (int k = 0; k < 12; k++) begin
            chk("R10 toggle", int'(wave_a), (k / 3) % 2);
            @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule